// File: doc/BRIEF.md
# Single-Phase Grid Synchronisation PLL

This block locks onto the phase and frequency of a sampled single-phase grid voltage with a rotating-frame phase-locked loop. Each accepted sample passes through two cascaded trapezoidal integrators. Together they produce a pair of signals 90° apart. That pair is rotated into a d-q frame using the sine and cosine left by the previous sample's update. The q component is the phase error. A saturating PI regulator turns the error into a frequency correction, which is added to a nominal per-sample phase increment. The corrected increment is accumulated into an unsigned phase word that wraps at 2π. The same increment also sets the step of a coupled two-state recursion that provides the exported sine and cosine.

Samples enter on a valid/ready stream and results leave on a second one. Only one sample is in flight at a time. `in_ready` is high only while the block is idle, and a sample is taken on a clock edge where `in_valid` and `in_ready` are both high. The result appears a fixed number of edges later with `out_valid` high. While `out_ready` is low, `out_valid` and every result port hold their values. The next sample is not accepted until the result has been taken. `locked_o` is a plain status pin.

Top module: `grid_sync_pll`

## Requirements
- R1: `in_ready` is high only when no sample is in flight. After a sample is accepted, `in_ready` stays low until the result has been taken with `out_ready`.
- R2: `out_valid` rises on the 14th rising clock edge after the edge that accepted the sample.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `freq_o`, `theta_o`, `sin_o`, `cos_o` and `locked_o` stay unchanged.
- R4: After reset, `theta_o` is 0, `freq_o` equals NOM_INC, `sin_o` is 0, `cos_o` is 2^OFRAC, `locked_o` is 0, `out_valid` is 0 and `in_ready` is 1.
- R5: `freq_o` = NOM_INC + Δ. Δ = clamp(round(KP·uq/2^15) + I), where I is the integrator, updated as I = clamp(I + round(KI·uq/2^15)). Both clamps are symmetric at ±FREQ_LIM, and `freq_o` reaches those bounds when the error is large.
- R6: `theta_o` of each result equals the previous result's `theta_o` plus the new `freq_o`, modulo 2^PW.
- R7: Each integrator stage computes y(n) = y(n−1) + round(QUAD_K·(x(n)+x(n−1))/2^16). The rotation inputs are vα = −y1 and vβ = −y2. The phase error is uq = round((cos·vβ − sin·vα)/2^OFRAC) and is formed with the previous sample's sine and cosine. Result: the first sample after reset gives uq = −y2.
- R8: With all-zero samples, `freq_o` stays exactly NOM_INC and the n-th result has `theta_o` = n·NOM_INC mod 2^PW.
- R9: The sine and cosine start at (0, 2^OFRAC) and advance as sin += round(h·cos/2^OFRAC), then cos −= round(h·sin_new/2^OFRAC). Here h = round(freq·2π·2^OFRAC/2^PW). They stay within 3% of full scale of sin/cos(2π·theta/2^PW).
- R10: `locked_o` rises with the result of the LOCK_N-th consecutive sample whose |uq| is below LOCK_TH. It clears with the result of any sample whose |uq| reaches LOCK_TH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample stream valid |
| in_ready | output | 1 | Sample stream ready; high only when idle |
| in_sample | input | DW | Signed voltage sample, 1.15 fixed point |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| freq_o | output | PW | Phase increment per sample (frequency estimate) |
| theta_o | output | PW | Unsigned phase word, full scale = 2π |
| sin_o | output | OW | Oscillator sine, OFRAC fraction bits |
| cos_o | output | OW | Oscillator cosine, OFRAC fraction bits |
| locked_o | output | 1 | Lock indication |

## Verification
The assertions assume that reset is held from time zero and that the handshake inputs are never unknown. They also assume that `in_sample` matters only on the accepting edge. They make no assumption about how often `out_ready` stalls. The stimulus raises `in_valid` only away from the clock edge and keeps it up until the block accepts the sample. Each result is held back by a random stall of zero to six cycles. Samples are zero runs, full-range values from a seeded generator, and a full-scale DC burst, which drives the integrators and the frequency clamp to saturation.

// File: rtl/grid_sync_pll_pkg.sv
package grid_sync_pll_pkg;

  // Processing steps of one sample, in the order they execute.
  typedef enum logic [3:0] {
    ST_IDLE, ST_Q0M, ST_Q0A, ST_Q1M, ST_Q1A, ST_ROT, ST_ERR, ST_PIM,
    ST_PIF, ST_HM, ST_HR, ST_XM, ST_XA, ST_YM, ST_YA, ST_OUT
  } step_e;

  // Arithmetic right shift with round-half-up.
  function automatic longint rnd_sh(longint v, int unsigned sh);
    if (sh == 0) return v;
    return (v + (longint'(1) <<< (sh - 1))) >>> sh;
  endfunction

  // Symmetric saturation to +/- lim.
  function automatic longint clamp_sym(longint v, longint lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

endpackage

// File: rtl/grid_sync_pll_quad.sv
module grid_sync_pll_quad
  import grid_sync_pll_pkg::*;
#(
  parameter int     DW     = 16,
  parameter int     QW     = 20,
  parameter int     KFRAC  = 16,
  parameter longint QUAD_K = 1029
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mul_en,
  input  logic [1:0]           add_en,
  input  logic signed [DW-1:0] sample,
  output logic signed [QW-1:0] alpha_o,
  output logic signed [QW-1:0] beta_o
);
  localparam int     NSTAGE = 2;
  localparam longint QMAX   = (longint'(1) <<< (QW - 1)) - 1;

  logic signed [QW-1:0] stage_y [NSTAGE];

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    logic signed [QW-1:0] y_q, prev_q;
    longint               prod_q;
    longint               x_in;

    if (g == 0) begin : g_first
      assign x_in = longint'(sample);
    end else begin : g_next
      assign x_in = longint'(stage_y[g-1]);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        y_q    <= '0;
        prev_q <= '0;
        prod_q <= 0;
      end else begin
        if (mul_en[g]) prod_q <= QUAD_K * (x_in + longint'(prev_q));
        if (add_en[g]) begin
          y_q    <= QW'(clamp_sym(longint'(y_q) + rnd_sh(prod_q, KFRAC), QMAX));
          prev_q <= QW'(x_in);
        end
      end
    end

    assign stage_y[g] = y_q;
  end

  // Symmetric saturation keeps the negation in range.
  assign alpha_o = -stage_y[0];
  assign beta_o  = -stage_y[1];
endmodule

// File: rtl/grid_sync_pll_loop.sv
module grid_sync_pll_loop
  import grid_sync_pll_pkg::*;
#(
  parameter int     PW       = 32,
  parameter int     UW       = 20,
  parameter int     UFRAC    = 15,
  parameter longint KP       = 1000000,
  parameter longint KI       = 1000,
  parameter longint NOM_INC  = 21474836,
  parameter longint FREQ_LIM = 2147484
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mul_en,
  input  logic                 upd_en,
  input  logic signed [UW-1:0] uq,
  output logic [PW-1:0]        freq_o,
  output logic [PW-1:0]        theta_o
);
  longint               pp_q, pi_q;
  logic signed [PW-1:0] integ_q;
  longint               integ_nx, dw_nx;
  logic [PW-1:0]        freq_nx;

  always_comb begin
    integ_nx = clamp_sym(longint'(integ_q) + rnd_sh(pi_q, UFRAC), FREQ_LIM);
    dw_nx    = clamp_sym(rnd_sh(pp_q, UFRAC) + integ_nx, FREQ_LIM);
    freq_nx  = PW'(NOM_INC + dw_nx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pp_q    <= 0;
      pi_q    <= 0;
      integ_q <= '0;
      freq_o  <= PW'(NOM_INC);
      theta_o <= '0;
    end else begin
      if (mul_en) begin
        pp_q <= KP * longint'(uq);
        pi_q <= KI * longint'(uq);
      end
      if (upd_en) begin
        integ_q <= PW'(integ_nx);
        freq_o  <= freq_nx;
        theta_o <= theta_o + freq_nx;
      end
    end
  end
endmodule

// File: rtl/grid_sync_pll_osc.sv
module grid_sync_pll_osc
  import grid_sync_pll_pkg::*;
#(
  parameter int PW    = 32,
  parameter int OW    = 24,
  parameter int OFRAC = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hm_en,
  input  logic                 hr_en,
  input  logic                 xm_en,
  input  logic                 xa_en,
  input  logic                 ym_en,
  input  logic                 ya_en,
  input  logic [PW-1:0]        freq,
  output logic signed [OW-1:0] sin_o,
  output logic signed [OW-1:0] cos_o
);
  localparam longint TWO_PI_Q = longint'(6.283185307179586 * (2.0 ** OFRAC));

  longint               mh_q, m_q;
  logic signed [OW-1:0] h_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mh_q  <= 0;
      m_q   <= 0;
      h_q   <= '0;
      sin_o <= '0;
      cos_o <= OW'(longint'(1) <<< OFRAC);
    end else begin
      if (hm_en) mh_q <= longint'({1'b0, freq}) * TWO_PI_Q;
      if (hr_en) h_q  <= OW'(rnd_sh(mh_q, PW));
      if (xm_en) m_q  <= longint'(h_q) * longint'(cos_o);
      if (xa_en) sin_o <= OW'(longint'(sin_o) + rnd_sh(m_q, OFRAC));
      if (ym_en) m_q  <= longint'(h_q) * longint'(sin_o);
      if (ya_en) cos_o <= OW'(longint'(cos_o) - rnd_sh(m_q, OFRAC));
    end
  end
endmodule

// File: rtl/grid_sync_pll.sv
module grid_sync_pll
  import grid_sync_pll_pkg::*;
#(
  parameter int     DW       = 16,
  parameter int     QW       = 20,
  parameter int     OW       = 24,
  parameter int     OFRAC    = 20,
  parameter int     PW       = 32,
  parameter int     KFRAC    = 16,
  parameter longint QUAD_K   = 1029,
  parameter longint NOM_INC  = 21474836,
  parameter longint KP       = 1000000,
  parameter longint KI       = 1000,
  parameter longint FREQ_LIM = 2147484,
  parameter longint LOCK_TH  = 64,
  parameter int     LOCK_N   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_sample,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PW-1:0]        freq_o,
  output logic [PW-1:0]        theta_o,
  output logic signed [OW-1:0] sin_o,
  output logic signed [OW-1:0] cos_o,
  output logic                 locked_o
);
  localparam int     UW    = QW;
  localparam int     UFRAC = DW - 1;
  localparam longint UMAX  = (longint'(1) <<< (UW - 1)) - 1;
  localparam int     CW    = $clog2(LOCK_N + 1);

  step_e                state_q, state_d;
  logic signed [DW-1:0] x_q;
  logic signed [QW-1:0] alpha, beta;
  longint               ms_q, mc_q;
  logic signed [UW-1:0] uq_q;
  logic [CW-1:0]        lock_cnt_q;
  longint               uq_abs;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (in_valid) state_d = ST_Q0M;
      ST_OUT:  if (out_ready) state_d = ST_IDLE;
      default: state_d = step_e'(state_q + 4'd1);
    endcase
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_OUT);
  assign uq_abs    = (uq_q < 0) ? -longint'(uq_q) : longint'(uq_q);
  assign locked_o  = (lock_cnt_q == CW'(LOCK_N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      x_q        <= '0;
      ms_q       <= 0;
      mc_q       <= 0;
      uq_q       <= '0;
      lock_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && in_valid) x_q <= in_sample;
      if (state_q == ST_ROT) begin
        ms_q <= longint'(sin_o) * longint'(alpha);
        mc_q <= longint'(cos_o) * longint'(beta);
      end
      if (state_q == ST_ERR)
        uq_q <= UW'(clamp_sym(rnd_sh(mc_q - ms_q, OFRAC), UMAX));
      if (state_q == ST_PIM) begin
        if (uq_abs >= LOCK_TH)                lock_cnt_q <= '0;
        else if (lock_cnt_q != CW'(LOCK_N))   lock_cnt_q <= lock_cnt_q + 1'b1;
      end
    end
  end

  grid_sync_pll_quad #(
    .DW(DW), .QW(QW), .KFRAC(KFRAC), .QUAD_K(QUAD_K)
  ) quad_i (
    .clk(clk), .rst_n(rst_n),
    .mul_en({state_q == ST_Q1M, state_q == ST_Q0M}),
    .add_en({state_q == ST_Q1A, state_q == ST_Q0A}),
    .sample(x_q), .alpha_o(alpha), .beta_o(beta)
  );

  grid_sync_pll_loop #(
    .PW(PW), .UW(UW), .UFRAC(UFRAC), .KP(KP), .KI(KI),
    .NOM_INC(NOM_INC), .FREQ_LIM(FREQ_LIM)
  ) loop_i (
    .clk(clk), .rst_n(rst_n),
    .mul_en(state_q == ST_PIM), .upd_en(state_q == ST_PIF),
    .uq(uq_q), .freq_o(freq_o), .theta_o(theta_o)
  );

  grid_sync_pll_osc #(
    .PW(PW), .OW(OW), .OFRAC(OFRAC)
  ) osc_i (
    .clk(clk), .rst_n(rst_n),
    .hm_en(state_q == ST_HM), .hr_en(state_q == ST_HR),
    .xm_en(state_q == ST_XM), .xa_en(state_q == ST_XA),
    .ym_en(state_q == ST_YM), .ya_en(state_q == ST_YA),
    .freq(freq_o), .sin_o(sin_o), .cos_o(cos_o)
  );
endmodule

// File: rtl/grid_sync_pll_chk.sv
module grid_sync_pll_chk #(
  parameter int     PW       = 32,
  parameter int     OW       = 24,
  parameter longint NOM_INC  = 21474836,
  parameter longint FREQ_LIM = 2147484
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [PW-1:0]        freq_o,
  input logic [PW-1:0]        theta_o,
  input logic signed [OW-1:0] sin_o,
  input logic signed [OW-1:0] cos_o,
  input logic                 locked_o
);
  localparam int LAT = 14;

  logic [5:0]    lat_cnt;
  logic          ov_d;
  logic [PW-1:0] prev_theta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt    <= '0;
      ov_d       <= 1'b0;
      prev_theta <= '0;
    end else begin
      ov_d <= out_valid;
      if (in_valid && in_ready)             lat_cnt <= '0;
      else if (!out_valid && lat_cnt != '1) lat_cnt <= lat_cnt + 1'b1;
      if (out_valid && !ov_d)               prev_theta <= theta_o;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);  // R1
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == 6'(LAT)));  // R2
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(freq_o) && $stable(theta_o)
      && $stable(sin_o) && $stable(cos_o) && $stable(locked_o)));  // R3
  AST_FREQ_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'(freq_o) <= NOM_INC + FREQ_LIM
                   && longint'(freq_o) >= NOM_INC - FREQ_LIM));  // R5
  AST_THETA_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (theta_o == PW'(prev_theta + freq_o)));  // R6
  AST_LOCK_MIDSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(locked_o) |-> (!in_ready && !out_valid));  // R10
endmodule

bind grid_sync_pll grid_sync_pll_chk #(
  .PW(PW), .OW(OW), .NOM_INC(NOM_INC), .FREQ_LIM(FREQ_LIM)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .freq_o(freq_o),
  .theta_o(theta_o), .sin_o(sin_o), .cos_o(cos_o), .locked_o(locked_o)
);

// File: tb/grid_sync_pll_tb_top.sv
module grid_sync_pll_tb_top;
  localparam int     DW = 16, OW = 24, OFRAC = 20, PW = 32;
  localparam longint QUAD_K = 1029, NOM = 21474836, KP = 1000000, KI = 1000;
  localparam longint LIM = 2147484, LOCK_TH = 64;
  localparam int     LOCK_N = 16;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic signed [DW-1:0] in_sample = '0;
  logic in_ready, out_valid, locked_o;
  logic [PW-1:0] freq_o, theta_o;
  logic signed [OW-1:0] sin_o, cos_o;

  int n_chk = 0, n_bad = 0;
  logic [PW-1:0] cap_f, cap_t;
  logic signed [OW-1:0] cap_s, cap_c;
  logic cap_l;
  int lat;

  always #5 clk = ~clk;

  grid_sync_pll #(
    .DW(DW), .OW(OW), .OFRAC(OFRAC), .PW(PW), .QUAD_K(QUAD_K), .NOM_INC(NOM),
    .KP(KP), .KI(KI), .FREQ_LIM(LIM), .LOCK_TH(LOCK_TH), .LOCK_N(LOCK_N)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .freq_o(freq_o), .theta_o(theta_o), .sin_o(sin_o), .cos_o(cos_o),
    .locked_o(locked_o)
  );

  function automatic longint rnd(longint v, int sh);
    return (v + (longint'(1) <<< (sh - 1))) >>> sh;
  endfunction

  function automatic longint clampv(longint v, longint l);
    return (v > l) ? l : ((v < -l) ? -l : v);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One sample through the block, result held back for 'hold' cycles.
  task automatic xfer(input logic signed [DW-1:0] smp, input int hold);
    bit stable_ok = 1'b1;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_sample = smp;
    @(posedge clk); #1 in_valid = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!out_valid);
    cap_f = freq_o; cap_t = theta_o; cap_s = sin_o; cap_c = cos_o; cap_l = locked_o;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!out_valid || in_ready || freq_o != cap_f || theta_o != cap_t ||
          sin_o != cap_s || cos_o != cap_c || locked_o != cap_l) stable_ok = 1'b0;
    end
    if (hold > 0) check(stable_ok, "R3/R1 hold during stall", longint'(stable_ok), 1);
    out_ready = 1'b1;
    @(posedge clk); #1 out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    longint y1, y2, uq, dw, tol, ideal;
    logic [PW-1:0] prev_t;
    bit hit_lim, lock_dropped;
    void'($urandom(32'd20250611));

    // R4: reset state
    do_reset();
    check(theta_o == '0, "R4 theta", longint'(theta_o), 0);
    check(freq_o == PW'(NOM), "R4 freq", longint'(freq_o), NOM);
    check(sin_o == '0, "R4 sin", longint'(sin_o), 0);
    check(cos_o == OW'(longint'(1) <<< OFRAC), "R4 cos", longint'(cos_o), longint'(1) <<< OFRAC);
    check(!locked_o, "R4 locked", longint'(locked_o), 0);
    check(!out_valid && in_ready, "R4 handshake idle", longint'({out_valid, in_ready}), 1);

    // R7: first sample after reset, exact step response
    xfer(16'sd16384, 3);
    y1 = rnd(QUAD_K * 16384, 16);
    y2 = rnd(QUAD_K * y1, 16);
    uq = -y2;
    dw = clampv(rnd(KP * uq, 15) + clampv(rnd(KI * uq, 15), LIM), LIM);
    check(longint'(cap_f) == NOM + dw, "R7 freq after step", longint'(cap_f), NOM + dw);
    check(cap_t == PW'(NOM + dw), "R6 theta first step", longint'(cap_t), NOM + dw);
    check(lat == 15, "R2 latency (negedges incl. accept)", lat, 15);

    // R8/R9/R10: zero input run
    do_reset();
    tol = longint'(0.03 * (2.0 ** OFRAC));
    for (int k = 1; k <= 300; k++) begin
      xfer(16'sd0, (k % 7 == 0) ? int'($urandom_range(1, 6)) : 0);
      check(cap_f == PW'(NOM), "R8 freq nominal", longint'(cap_f), NOM);
      check(cap_t == PW'(longint'(k) * NOM), "R8 theta n*NOM", longint'(cap_t),
            longint'(PW'(longint'(k) * NOM)));
      check(cap_l == (k >= LOCK_N), "R10 lock count", longint'(cap_l), longint'(k >= LOCK_N));
      if (k % 25 == 0) begin
        ideal = longint'($sin(6.283185307179586 * real'(cap_t) / (2.0 ** PW)) * (2.0 ** OFRAC));
        check((longint'(cap_s) - ideal) <= tol && (ideal - longint'(cap_s)) <= tol,
              "R9 sine tracks theta", longint'(cap_s), ideal);
        ideal = longint'($cos(6.283185307179586 * real'(cap_t) / (2.0 ** PW)) * (2.0 ** OFRAC));
        check((longint'(cap_c) - ideal) <= tol && (ideal - longint'(cap_c)) <= tol,
              "R9 cosine tracks theta", longint'(cap_c), ideal);
      end
    end

    // R5/R6/R10: constrained random then full-scale DC burst
    prev_t = cap_t; hit_lim = 1'b0; lock_dropped = 1'b0;
    for (int k = 0; k < 450; k++) begin
      logic signed [DW-1:0] s;
      s = (k < 200) ? DW'($urandom) : 16'sd32767;
      xfer(s, int'($urandom_range(0, 2)));
      check(longint'(cap_f) <= NOM + LIM && longint'(cap_f) >= NOM - LIM,
            "R5 freq within clamp", longint'(cap_f), NOM);
      check(cap_t == PW'(prev_t + cap_f), "R6 theta accumulates", longint'(cap_t),
            longint'(PW'(prev_t + cap_f)));
      prev_t = cap_t;
      if (longint'(cap_f) == NOM + LIM || longint'(cap_f) == NOM - LIM) hit_lim = 1'b1;
      if (!cap_l) lock_dropped = 1'b1;
    end
    check(hit_lim, "R5 clamp reached", longint'(hit_lim), 1);
    check(lock_dropped, "R10 lock clears on large error", longint'(lock_dropped), 1);

    summary();
  end
endmodule